// File: doc/BRIEF.md
# Receive Ring Pointer Manager

This block tracks the write and read positions of a circular receive area held in a byte-addressed packet memory. A host uses a byte-wide register port to place the area (a first and a last address, both inside the area) and to hand back space by moving the read pointer. A receive source delivers packets as a start strobe, one strobe per data byte, and a closing strobe that marks the packet as good or bad. For each accepted byte the block drives a memory write with the address taken from its working write pointer.

Two write pointers are kept. The working pointer advances byte by byte and is never visible to the host. The committed pointer, which the host can read, moves only when a packet closes as good. A bad packet, or one that runs out of room, is discarded by rewinding the working pointer to where that packet began. The block also reports how many bytes are free, a sticky overflow flag and a sticky warning for an odd first address.

Top module: `rx_ring_ptr`

## Requirements
- R1: The area covers every address from the first address up to and including the last address. After the last address the working pointer continues at the first address.
- R2: A write to any byte of the first or last address loads the working pointer with the first address at once. The first byte of the next packet is written there.
- R3: The committed pointer (register 6 low, 7 high) does not change when the area bounds are programmed. It changes only on a good packet end.
- R4: The read pointer is written low byte (register 4) first, then high byte (register 5). A write to the low byte alone changes neither the read pointer nor the free count.
- R5: A write of an odd first address is accepted. It sets a sticky warning (status register 8 bit 1, also the `odd_start` pin). Writing status with bit 1 set clears the warning.
- R6: A bad packet end discards the packet. The next packet starts at the address where the discarded packet began.
- R7: `free_space` is the count of bytes from the working pointer forward to the read pointer, wrap included, minus one. A ring of N bytes is therefore empty at N-1.
- R8: A byte that would move the working pointer onto the read pointer is not written. The whole packet is dropped and rewound, and the sticky overflow flag (status bit 0, `overflow` pin) is set. Writing status with bit 0 set clears it.
- R9: On a good end, if the working pointer is odd it advances one pad location before it is committed. If that pad would reach the read pointer, the packet is treated as an overflow (R8).
- R10: Until `clk_rdy` has been seen high after reset, writes to registers 0 to 5 are ignored.
- R11: Strobes are one per cycle with priority start, bad end, good end, byte. Bytes outside a packet are ignored. A start inside a packet abandons that packet. The register read map is: 0/1 first address low/high, 2/3 last address, 4/5 read pointer, 6/7 committed pointer, 8 status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_rdy | input | 1 | Oscillator ready indication |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register index |
| cfg_wdata | input | 8 | Register write byte |
| cfg_rdata | output | 8 | Register read byte (combinational) |
| rx_sof | input | 1 | Packet start strobe |
| rx_valid | input | 1 | Data byte strobe |
| rx_data | input | 8 | Data byte |
| rx_eof_ok | input | 1 | Packet ended good |
| rx_eof_err | input | 1 | Packet ended bad |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W | Memory write address |
| mem_wdata | output | 8 | Memory write byte |
| free_space | output | ADDR_W | Free bytes in the ring |
| overflow | output | 1 | Sticky overflow flag |
| odd_start | output | 1 | Sticky odd first address warning |

## Verification
The hardest case to reach is the pad location hitting the read pointer. It needs an odd packet length that ends exactly one location short of the read pointer, and that occurs only for particular pairs of length and read position. The bench uses a 16-byte ring and sweeps every packet length from 1 to 20 in turn. Between packets it sometimes frees the whole ring and sometimes leaves it partly full, so the working pointer wraps, packets overflow in mid-byte, and packets hit the pad collision, with each expected address computed arithmetically.

// File: rtl/rx_ring_ptr.sv
module rx_ring_ptr #(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_rdy,
  input  logic              cfg_we,
  input  logic [3:0]        cfg_addr,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  input  logic              rx_sof,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  input  logic              rx_eof_ok,
  input  logic              rx_eof_err,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic [ADDR_W-1:0] free_space,
  output logic              overflow,
  output logic              odd_start
);
  localparam int HI_W = ADDR_W - 8;
  localparam logic [ADDR_W-1:0] INC = 1;
  localparam logic [ADDR_W:0] ONE = 1;

  logic [ADDR_W-1:0] st, en, rd, wc, ww, base;
  logic [7:0] rd_lo;
  logic rdy_seen, active, drop, ovf, odd;

  logic ptr_wr, bound_wr, stat_wr;
  logic [ADDR_W-1:0] st_n, ww_nx, rnd;
  logic byte_ok, byte_full, pad_full;

  assign ptr_wr   = cfg_we & rdy_seen & (cfg_addr <= 4'd5);
  assign bound_wr = ptr_wr & (cfg_addr <= 4'd3);
  assign stat_wr  = cfg_we & (cfg_addr == 4'd8);

  always_comb begin
    st_n = st;
    if (ptr_wr && cfg_addr == 4'd0) st_n = {st[ADDR_W-1:8], cfg_wdata};
    if (ptr_wr && cfg_addr == 4'd1) st_n = {cfg_wdata[HI_W-1:0], st[7:0]};
  end

  assign ww_nx     = (ww == en) ? st : ww + INC;
  assign byte_full = (ww_nx == rd);
  assign pad_full  = ww[0] & byte_full;
  assign rnd       = ww[0] ? ww_nx : ww;
  assign byte_ok   = rx_valid & active & ~drop & ~bound_wr &
                     ~rx_sof & ~rx_eof_err & ~rx_eof_ok;

  assign mem_we    = byte_ok & ~byte_full;
  assign mem_addr  = ww;
  assign mem_wdata = rx_data;
  assign overflow  = ovf;
  assign odd_start = odd;

  logic [ADDR_W:0] size, free_w;
  assign size   = {1'b0, en} - {1'b0, st} + ONE;
  assign free_w = (rd > ww) ? ({1'b0, rd} - {1'b0, ww} - ONE)
                            : (size - ({1'b0, ww} - {1'b0, rd}) - ONE);
  assign free_space = free_w[ADDR_W-1:0];

  logic [15:0] st_x, en_x, rd_x, wc_x;
  assign st_x = 16'(st);
  assign en_x = 16'(en);
  assign rd_x = 16'(rd);
  assign wc_x = 16'(wc);

  always_comb begin
    case (cfg_addr)
      4'd0: cfg_rdata = st_x[7:0];
      4'd1: cfg_rdata = st_x[15:8];
      4'd2: cfg_rdata = en_x[7:0];
      4'd3: cfg_rdata = en_x[15:8];
      4'd4: cfg_rdata = rd_x[7:0];
      4'd5: cfg_rdata = rd_x[15:8];
      4'd6: cfg_rdata = wc_x[7:0];
      4'd7: cfg_rdata = wc_x[15:8];
      4'd8: cfg_rdata = {6'b0, odd, ovf};
      default: cfg_rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= '0;
      en <= '1;
      rd <= '0;
      wc <= '0;
      ww <= '0;
      base <= '0;
      rd_lo <= '0;
      rdy_seen <= 1'b0;
      active <= 1'b0;
      drop <= 1'b0;
      ovf <= 1'b0;
      odd <= 1'b0;
    end else begin
      if (clk_rdy) rdy_seen <= 1'b1;

      if (stat_wr) begin
        if (cfg_wdata[0]) ovf <= 1'b0;
        if (cfg_wdata[1]) odd <= 1'b0;
      end

      if (ptr_wr) begin
        case (cfg_addr)
          4'd0: begin
            st[7:0] <= cfg_wdata;
            if (cfg_wdata[0]) odd <= 1'b1;
          end
          4'd1: st[ADDR_W-1:8] <= cfg_wdata[HI_W-1:0];
          4'd2: en[7:0] <= cfg_wdata;
          4'd3: en[ADDR_W-1:8] <= cfg_wdata[HI_W-1:0];
          4'd4: rd_lo <= cfg_wdata;
          4'd5: rd <= {cfg_wdata[HI_W-1:0], rd_lo};
          default: ;
        endcase
      end

      if (bound_wr) begin
        ww <= st_n;
        active <= 1'b0;
        drop <= 1'b0;
      end else if (rx_sof) begin
        active <= 1'b1;
        drop <= 1'b0;
        if (active) ww <= base;
        else base <= ww;
      end else if (rx_eof_err) begin
        if (active) ww <= base;
        active <= 1'b0;
        drop <= 1'b0;
      end else if (rx_eof_ok) begin
        if (active && !drop) begin
          if (pad_full) begin
            ovf <= 1'b1;
            ww <= base;
          end else begin
            ww <= rnd;
            wc <= rnd;
          end
        end
        active <= 1'b0;
        drop <= 1'b0;
      end else if (byte_ok) begin
        if (byte_full) begin
          ovf <= 1'b1;
          drop <= 1'b1;
          ww <= base;
        end else begin
          ww <= ww_nx;
        end
      end
    end
  end
endmodule

module rx_ring_ptr_chk #(
  parameter int ADDR_W = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rdy_seen,
  input logic              cfg_we,
  input logic [3:0]        cfg_addr,
  input logic [ADDR_W-1:0] st,
  input logic [ADDR_W-1:0] en,
  input logic [ADDR_W-1:0] rd,
  input logic [ADDR_W-1:0] wc,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [ADDR_W-1:0] free_space,
  input logic              rx_eof_ok
);
  p_region_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && st <= en) |-> (mem_addr >= st && mem_addr <= en));

  p_commit_only_ok_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (wc == $past(wc)) || $past(rx_eof_ok));

  p_rd_lo_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == 4'd4) |=> $stable(rd));

  p_no_full_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (free_space != '0));

  p_even_commit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!st[0] && wc != $past(wc)) |-> !wc[0]);

  p_cfg_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!rdy_seen && cfg_we) |=> ($stable(st) && $stable(en) && $stable(rd)));
endmodule

bind rx_ring_ptr rx_ring_ptr_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rdy_seen(rdy_seen), .cfg_we(cfg_we),
  .cfg_addr(cfg_addr), .st(st), .en(en), .rd(rd), .wc(wc),
  .mem_we(mem_we), .mem_addr(mem_addr), .free_space(free_space),
  .rx_eof_ok(rx_eof_ok)
);

// File: tb/sim_rx_ring_ptr.sv
module sim_rx_ring_ptr;
  localparam int AW = 13;

  logic clk = 1'b0;
  logic rst_n, clk_rdy, cfg_we, rx_sof, rx_valid, rx_eof_ok, rx_eof_err;
  logic [3:0] cfg_addr;
  logic [7:0] cfg_wdata, cfg_rdata, rx_data, mem_wdata;
  logic mem_we, overflow, odd_start;
  logic [AW-1:0] mem_addr, free_space;

  always #4 clk = ~clk;

  rx_ring_ptr #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .clk_rdy(clk_rdy), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .rx_sof(rx_sof), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_eof_ok(rx_eof_ok), .rx_eof_err(rx_eof_err), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .free_space(free_space),
    .overflow(overflow), .odd_start(odd_start)
  );

  int n_chk = 0, n_bad = 0;
  int mst, men, mrd, mwc, mww, mbase, movf;
  bit mdrop;

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int mnxt(int p);
    return (p == men) ? mst : p + 1;
  endfunction

  function automatic int mfree();
    int sz = men - mst + 1;
    return (((mrd - mww - 1) % sz) + sz) % sz;
  endfunction

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(int a, int d);
    cfg_we = 1'b1; cfg_addr = 4'(a); cfg_wdata = 8'(d);
    cyc();
    cfg_we = 1'b0;
  endtask

  task automatic rd16(int a, output int v);
    int lo;
    cfg_addr = 4'(a); #1; lo = cfg_rdata;
    cfg_addr = 4'(a + 1); #1; v = {cfg_rdata, 8'(lo)};
  endtask

  task automatic set_rd(int v);
    wr(4, v & 255); wr(5, v >> 8);
    mrd = v;
  endtask

  task automatic pkt(int len, bit ok, string req);
    int v;
    rx_sof = 1'b1; cyc(); rx_sof = 1'b0;
    mbase = mww; mdrop = 0;
    for (int i = 0; i < len; i++) begin
      rx_valid = 1'b1; rx_data = 8'(i + 1); #1;
      chk({req, " R7 free"}, int'(free_space), mfree());
      if (mdrop) chk({req, " R8 dropped we"}, int'(mem_we), 0);
      else if (mnxt(mww) == mrd) begin
        chk({req, " R8 full we"}, int'(mem_we), 0);
        mdrop = 1; movf = 1; mww = mbase;
      end else begin
        chk({req, " R1 we"}, int'(mem_we), 1);
        chk({req, " R1 addr"}, int'(mem_addr), mww);
        mww = mnxt(mww);
      end
      cyc();
    end
    rx_valid = 1'b0;
    if (ok) rx_eof_ok = 1'b1; else rx_eof_err = 1'b1;
    cyc();
    rx_eof_ok = 1'b0; rx_eof_err = 1'b0;
    if (!ok) mww = mbase;
    else if (!mdrop) begin
      if (mww % 2 == 1) begin
        if (mnxt(mww) == mrd) begin movf = 1; mww = mbase; end
        else begin mww = mnxt(mww); mwc = mww; end
      end else mwc = mww;
    end
    rd16(6, v);
    chk({req, " R3 committed"}, v, mwc);
    chk({req, " R8 ovf"}, int'(overflow), movf);
  endtask

  bit done = 0;
  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    int v;
    rst_n = 1'b0; clk_rdy = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    rx_sof = 0; rx_valid = 0; rx_data = '0; rx_eof_ok = 0; rx_eof_err = 0;
    cyc(); cyc();
    rst_n = 1'b1;
    #1;
    chk("reset R7 free", int'(free_space), (1 << AW) - 1);
    chk("reset R8 ovf", int'(overflow), 0);
    rd16(6, v); chk("reset R3 committed", v, 0);

    wr(0, 8'h55);
    rd16(0, v); chk("R10 gated write", v, 0);
    clk_rdy = 1'b1; cyc(); clk_rdy = 1'b0;

    wr(0, 8'h00); wr(1, 8'h01); wr(2, 8'h0F); wr(3, 8'h01);
    mst = 'h100; men = 'h10F; mww = 'h100; mwc = 0; movf = 0;
    rd16(2, v); chk("R10 write after ready", v, 'h10F);
    rd16(6, v); chk("R3 bounds keep committed", v, 0);
    set_rd('h100);
    #1; chk("R7 empty ring", int'(free_space), 15);

    for (int len = 1; len <= 20; len++) begin
      pkt(len, 1'b1, "sweep R11");
      if (movf) begin wr(8, 1); movf = 0; #1; chk("R8 clear", int'(overflow), 0); end
      if (len % 3 != 0) set_rd(mwc);
    end

    set_rd(mwc);
    pkt(3, 1'b1, "good R9");
    pkt(5, 1'b0, "bad R6");
    pkt(2, 1'b1, "after bad R6");

    v = int'(free_space);
    wr(4, (mrd + 4) & 255);
    #1; chk("R4 low only free", int'(free_space), v);
    rd16(4, v); chk("R4 low only ptr", v, mrd);
    wr(5, (mrd + 4) >> 8); mrd = mrd + 4;
    #1; chk("R4 commit free", int'(free_space), mfree());

    wr(2, 8'h0F); mww = mst;
    rx_sof = 1'b1; cyc(); rx_sof = 1'b0;
    rx_valid = 1'b1; #1;
    chk("R2 reload addr", int'(mem_addr), mst);
    cyc(); rx_valid = 1'b0;
    rx_eof_err = 1'b1; cyc(); rx_eof_err = 1'b0;
    rd16(6, v); chk("R2 R3 committed kept", v, mwc);

    rx_valid = 1'b1; cyc(); rx_valid = 1'b0;
    #1; chk("R11 stray byte ignored", int'(free_space), mfree());

    wr(0, 8'h01); #1;
    chk("R5 warn set", int'(odd_start), 1);
    rd16(0, v); chk("R5 write accepted", v, 'h101);
    wr(8, 2); #1;
    chk("R5 warn cleared", int'(odd_start), 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule